// File: doc/BRIEF.md
# Watchdog Failsafe Output Controller

This block watches the outcome of a periodic watchdog service and drives three active-low safety outputs. The outputs are a limp-home output, an interrupt output and a reset output. The window timing is checked elsewhere. This block receives one strobe per correct service and one strobe per incorrect service. It keeps a saturating error counter. A failure is declared when an incorrect service leaves that counter at or above a threshold.

On a failure, the limp output is asserted if it is enabled. It is released according to one of three programmable recovery policies. The same failure can set an interrupt status bit, start a fixed-length low pulse on the reset output, or both. The reset output can also follow a digital undervoltage flag. The choice of sources for the reset output is programmable.

Interrupt status bits latch and are cleared by writing 1 to them. A mask hides a bit from the interrupt pin without stopping it from latching. Software reaches the block through a simple register port: a write strobe, an address and write data, with read data available in the same cycle.

Register map:
- 0: configuration.
- 1: control.
- 2: error count, read-only.
- 3: interrupt status.
- 4: interrupt mask.

Configuration bits:
- bit 0: limp enable.
- bits [2:1]: recovery policy.
- bits [4:3]: watchdog action.
- bits [6:5]: reset source.
- bit 7: spare, stored and read back.

Top module: `wdfs_ctrl`

## Requirements
- R1: After reset, limp_n, int_n and rst_out_n are all 1. Address 2 reads 4, address 0 reads 0x01 (limp enabled, policy 00, action 00, source 00), and addresses 3 and 4 read 0.
- R2: The error count (address 2, bits [3:0]) rises by 1 on each incorrect service and falls by 1 on each correct service. It saturates at 15 and at 0. If both strobes arrive in the same cycle, the service counts as incorrect. Register writes to address 2 are ignored.
- R3: An incorrect service that leaves the error count at 5 or more is a watchdog event. While limp enable (address 0 bit 0) is 1, a watchdog event drives limp_n to 0.
- R4: With recovery policy 00 (address 0 bits [2:1]), limp_n returns to 1 after three consecutive correct services. Any incorrect service restarts that count from zero.
- R5: With recovery policy 01, one correct service returns limp_n to 1.
- R6: With recovery policy 10 or 11, correct services never release limp_n. Under any policy, writing 1 to address 1 bit 0 releases it. Address 1 always reads 0.
- R7: While limp enable is 0, limp_n stays 1 whatever the policy. Clearing the enable releases an asserted limp output.
- R8: Interrupt status (address 3) sets bit 0 on every incorrect service and bit 1 in every cycle the undervoltage flag is high. It sets bit 2 on a watchdog event when the watchdog action (address 0 bits [4:3]) is 00 or 10. Writing 1 clears a bit, and a new setting in the same cycle wins. int_n is 0 while any status bit is 1 and its mask bit (address 4) is 0. Masked bits still latch and read back.
- R9: With watchdog action 01 or 10, a watchdog event drives rst_out_n low for exactly 16 cycles. This applies when the reset source (address 0 bits [6:5]) is 00 or 10. A new event restarts the 16 cycles.
- R10: With reset source 01 or 10, rst_out_n is 0 in the cycle after each cycle of undervoltage. With source 00 or 11, undervoltage has no effect on rst_out_n. With source 01 or 11, watchdog pulses do not reach rst_out_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| svc_ok | input | 1 | One-cycle strobe for a correct watchdog service |
| svc_bad | input | 1 | One-cycle strobe for an incorrect watchdog service |
| uv_flag | input | 1 | Supply undervoltage indication, level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| limp_n | output | 1 | Limp-home output, active low |
| int_n | output | 1 | Interrupt output, active low |
| rst_out_n | output | 1 | Reset output, active low |

## Verification
Every strobe or undervoltage effect is due at the first rising edge after the cycle in which it is presented. This covers the error count, the limp output, the status bits, int_n and rst_out_n. A register write takes effect at its own edge. Configuration written there governs only the strobes of later cycles. The bench therefore drives each stimulus just after a falling edge, lets one rising edge pass, and samples at the following falling edge. The reset pulse is followed sample by sample to confirm 16 low cycles and a high 17th. Changes of policy are separated from the strobes they govern by at least one cycle.

// File: rtl/wdfs_pkg.sv
package wdfs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NST    = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CFG  = 3'd0;
  localparam addr_t A_CTRL = 3'd1;
  localparam addr_t A_ERR  = 3'd2;
  localparam addr_t A_STAT = 3'd3;
  localparam addr_t A_MASK = 3'd4;

  typedef enum logic [1:0] {
    REC_COUNTED = 2'b00,
    REC_SINGLE  = 2'b01,
    REC_SOFT    = 2'b10,
    REC_SOFT_B  = 2'b11
  } rec_e;

  typedef enum logic [1:0] {
    ACT_IRQ  = 2'b00,
    ACT_RST  = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_NONE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    SRC_WD  = 2'b00,
    SRC_UV  = 2'b01,
    SRC_ANY = 2'b10,
    SRC_OFF = 2'b11
  } src_e;

  typedef struct packed {
    logic spare;
    src_e src;
    act_e act;
    rec_e rec;
    logic limp_en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{spare: 1'b0, src: SRC_WD, act: ACT_IRQ,
                               rec: REC_COUNTED, limp_en: 1'b1};
endpackage

// File: rtl/wdfs_errcnt.sv
module wdfs_errcnt #(
  parameter int CNT_W    = 4,
  parameter int CNT_INIT = 4,
  parameter int FAIL_THR = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bad,
  input  logic             ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wd_event
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] INIT_V  = CNT_W'(CNT_INIT);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign cnt_ce = bad | ok;

  always_comb begin
    cnt_d = cnt_q;
    if (bad) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (ok) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  assign wd_event = bad && (int'(cnt_d) >= FAIL_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_V;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R2: saturation and single steps
  a_r2_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    bad && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  a_r2_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ok && !bad && cnt_q == '0 |=> cnt_q == '0);
  a_r2_inc: assert property (@(posedge clk) disable iff (!rst_n)
    bad && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ok && !bad && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/wdfs_limp.sv
module wdfs_limp import wdfs_pkg::*; #(
  parameter int GOOD_NEED = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  rec_e rec,
  input  logic wd_event,
  input  logic ok,
  input  logic bad,
  input  logic soft_clr,
  output logic limp_q
);
  localparam int GW = $clog2(GOOD_NEED + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_NEED - 1);

  logic [GW-1:0] good_q, good_d;
  logic          limp_d;

  always_comb begin
    limp_d = limp_q;
    good_d = good_q;
    if (!en) begin
      limp_d = 1'b0;
      good_d = '0;
    end else if (wd_event) begin
      limp_d = 1'b1;
      good_d = '0;
    end else if (limp_q) begin
      if (soft_clr) begin
        limp_d = 1'b0;
        good_d = '0;
      end else if (bad) begin
        good_d = '0;
      end else if (ok) begin
        case (rec)
          REC_COUNTED: begin
            if (good_q == GOOD_LAST) begin
              limp_d = 1'b0;
              good_d = '0;
            end else begin
              good_d = good_q + 1'b1;
            end
          end
          REC_SINGLE: limp_d = 1'b0;
          default:    limp_d = limp_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limp_q <= 1'b0;
      good_q <= '0;
    end else begin
      limp_q <= limp_d;
      good_q <= good_d;
    end
  end

  // R7: disabled limp never stays asserted
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !limp_q);
  // R3: event with enable asserts limp
  a_r3_assert: assert property (@(posedge clk) disable iff (!rst_n)
    en && wd_event |=> limp_q);
  // R6: software-only policies hold without the clear bit
  a_r6_soft_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en && limp_q && (rec == REC_SOFT || rec == REC_SOFT_B) && !soft_clr |=> limp_q);
  // R5: single good service releases
  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    en && limp_q && rec == REC_SINGLE && ok && !bad && !wd_event |=> !limp_q);
endmodule

// File: rtl/wdfs_pulse.sv
module wdfs_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active_nx
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LOAD_V = PW'(PULSE_LEN);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  assign cnt_ce = trig | (cnt_q != '0);

  always_comb begin
    if (trig)             cnt_d = LOAD_V;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  assign active_nx = (cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R9: a trigger loads the full length, then the count walks down by one
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cnt_q == LOAD_V);
  a_r9_walk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/wdfs_regs.sv
module wdfs_regs import wdfs_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  addr_t             addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NST-1:0]    st_set,
  input  logic [CNT_W-1:0]  err_cnt,
  output cfg_t              cfg_q,
  output logic              soft_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n_q
);
  logic [NST-1:0] stat_q, stat_d, mask_q, mask_d, w1c;
  logic           wr_cfg, wr_stat, wr_mask, irq_n_d;

  assign wr_cfg   = we && (addr == A_CFG);
  assign wr_stat  = we && (addr == A_STAT);
  assign wr_mask  = we && (addr == A_MASK);
  assign soft_clr = we && (addr == A_CTRL) && wdata[0];

  assign w1c     = wr_stat ? wdata[NST-1:0] : '0;
  assign stat_d  = (stat_q & ~w1c) | st_set;
  assign mask_d  = wr_mask ? wdata[NST-1:0] : mask_q;
  assign irq_n_d = ~|(stat_d & ~mask_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      stat_q  <= '0;
      mask_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (wr_cfg) cfg_q <= cfg_t'(wdata);
      stat_q  <= stat_d;
      mask_q  <= mask_d;
      irq_n_q <= irq_n_d;
    end
  end

  always_comb begin
    case (addr)
      A_CFG:   rdata = cfg_q;
      A_ERR:   rdata = {{(DATA_W-CNT_W){1'b0}}, err_cnt};
      A_STAT:  rdata = {{(DATA_W-NST){1'b0}}, stat_q};
      A_MASK:  rdata = {{(DATA_W-NST){1'b0}}, mask_q};
      default: rdata = '0;
    endcase
  end

  // R8: status bits are sticky unless a clear write touches them
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R8: pin reflects unmasked stored status
  a_r8_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_q == ~|(stat_q & ~mask_q));
  // R6: control register never reads as set
  a_r6_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_CTRL |-> rdata == '0);
endmodule

// File: rtl/wdfs_ctrl.sv
module wdfs_ctrl import wdfs_pkg::*; #(
  parameter int CNT_W     = 4,
  parameter int CNT_INIT  = 4,
  parameter int FAIL_THR  = 5,
  parameter int GOOD_NEED = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_ok,
  input  logic        svc_bad,
  input  logic        uv_flag,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        limp_n,
  output logic        int_n,
  output logic        rst_out_n
);
  logic [CNT_W-1:0] err_cnt;
  logic             wd_event, limp_q, soft_clr, pulse_nx;
  logic             ok_eff, pulse_trig, wd_src, uv_src, rst_d, rst_q;
  logic [NST-1:0]   st_set;
  cfg_t             cfg;

  assign ok_eff     = svc_ok & ~svc_bad;
  assign pulse_trig = wd_event && (cfg.act == ACT_RST || cfg.act == ACT_BOTH);
  assign st_set     = {wd_event && (cfg.act == ACT_IRQ || cfg.act == ACT_BOTH),
                       uv_flag, svc_bad};
  assign wd_src     = (cfg.src == SRC_WD) || (cfg.src == SRC_ANY);
  assign uv_src     = (cfg.src == SRC_UV) || (cfg.src == SRC_ANY);
  assign rst_d      = ~((pulse_nx && wd_src) || (uv_flag && uv_src));

  wdfs_errcnt #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT), .FAIL_THR(FAIL_THR)) u_err (
    .clk(clk), .rst_n(rst_n), .bad(svc_bad), .ok(svc_ok),
    .cnt_q(err_cnt), .wd_event(wd_event));

  wdfs_limp #(.GOOD_NEED(GOOD_NEED)) u_limp (
    .clk(clk), .rst_n(rst_n), .en(cfg.limp_en), .rec(cfg.rec),
    .wd_event(wd_event), .ok(ok_eff), .bad(svc_bad),
    .soft_clr(soft_clr), .limp_q(limp_q));

  wdfs_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(pulse_trig), .active_nx(pulse_nx));

  wdfs_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .st_set(st_set), .err_cnt(err_cnt),
    .cfg_q(cfg), .soft_clr(soft_clr), .rdata(reg_rdata), .irq_n_q(int_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b1;
    else        rst_q <= rst_d;
  end

  assign limp_n    = ~limp_q;
  assign rst_out_n = rst_q;

  // R10: undervoltage reaches the reset pin when selected
  a_r10_uv: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag && uv_src |=> !rst_out_n);
  // R10: source off keeps the reset pin high
  a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.src == SRC_OFF |=> rst_out_n);
  // R9: a routed pulse trigger pulls the reset pin low
  a_r9_trig: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_trig && wd_src |=> !rst_out_n);
endmodule

// File: tb/wdfs_ctrl_tb.sv
module wdfs_ctrl_tb;
  logic       clk, rst_n, svc_ok, svc_bad, uv_flag, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       limp_n, int_n, rst_out_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wdfs_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .svc_ok(svc_ok), .svc_bad(svc_bad),
    .uv_flag(uv_flag), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .limp_n(limp_n),
    .int_n(int_n), .rst_out_n(rst_out_n));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {bad, ok, exp_cnt[3:0], exp_limp_n, exp_int_n}
  localparam int NV = 18;
  localparam logic [7:0] VEC [NV] = '{
    8'b01001111, 8'b01001011, 8'b01000111, 8'b01000011, 8'b01000011,
    8'b10000110, 8'b10001010, 8'b10001110, 8'b10010010, 8'b10010100,
    8'b01010000, 8'b01001100, 8'b10010000, 8'b01001100, 8'b01001000,
    8'b01000110, 8'b11001010, 8'b00001010};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic o, input logic u);
    svc_bad = b; svc_ok = o; uv_flag = u;
    @(posedge clk);
    @(negedge clk);
    svc_bad = 1'b0; svc_ok = 1'b0; uv_flag = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; svc_ok = 0; svc_bad = 0; uv_flag = 0;
    reg_we = 0; reg_addr = 3'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {5'b0, limp_n, int_n, rst_out_n}, 8'h07);
    rd(3'd2, v); chk("R1 errcnt", v, 8'd4);
    rd(3'd0, v); chk("R1 cfg", v, 8'h01);
    rd(3'd3, v); chk("R1 status", v, 8'h00);
    rd(3'd4, v); chk("R1 mask", v, 8'h00);

    // vector table: R2 counter, R3 assert, R4 counted release, R8 pin
    reg_addr = 3'd2;
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][7], VEC[i][6], 1'b0);
      rd(3'd2, v);
      chk($sformatf("R2 count step %0d", i), v, {4'b0, VEC[i][5:2]});
      chk($sformatf("R3/R4 limp step %0d", i), {7'b0, limp_n}, {7'b0, VEC[i][1]});
      chk($sformatf("R8 int step %0d", i), {7'b0, int_n}, {7'b0, VEC[i][0]});
    end

    // R8 clear by writing ones
    wr(3'd3, 8'hFF);
    chk("R8 w1c int_n", {7'b0, int_n}, 8'd1);
    rd(3'd3, v); chk("R8 w1c status", v, 8'h00);

    // R2 saturation at 15 and ignored write
    for (int i = 0; i < 15; i++) cyc(1'b1, 1'b0, 1'b0);
    rd(3'd2, v); chk("R2 sat 15", v, 8'd15);
    wr(3'd2, 8'h00);
    rd(3'd2, v); chk("R2 write ignored", v, 8'd15);
    chk("R3 limp held at 15", {7'b0, limp_n}, 8'd0);

    // R5 single good release
    wr(3'd0, 8'h03);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R5 single release", {7'b0, limp_n}, 8'd1);

    // R6 software-only release
    wr(3'd0, 8'h05);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R6 assert", {7'b0, limp_n}, 8'd0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0);
    chk("R6 goods ignored", {7'b0, limp_n}, 8'd0);
    wr(3'd1, 8'h01);
    chk("R6 soft clear", {7'b0, limp_n}, 8'd1);
    rd(3'd1, v); chk("R6 ctrl reads 0", v, 8'h00);

    // R7 limp disabled
    wr(3'd0, 8'h00);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R7 disabled no assert", {7'b0, limp_n}, 8'd1);
    wr(3'd0, 8'h01);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R7 enabled assert", {7'b0, limp_n}, 8'd0);
    wr(3'd0, 8'h00);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R7 disable releases", {7'b0, limp_n}, 8'd1);

    // R8 mask hides pin but status still latches
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'h05);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R8 masked pin", {7'b0, int_n}, 8'd1);
    rd(3'd3, v); chk("R8 masked latch", v, 8'h05);
    wr(3'd4, 8'h00);
    chk("R8 unmask pin", {7'b0, int_n}, 8'd0);

    // R9 reset pulse length
    wr(3'd0, 8'h08);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R9 pulse start", {7'b0, rst_out_n}, 8'd0);
    for (int i = 0; i < 15; i++) begin
      cyc(1'b0, 1'b0, 1'b0);
      chk($sformatf("R9 pulse low %0d", i), {7'b0, rst_out_n}, 8'd0);
    end
    cyc(1'b0, 1'b0, 1'b0);
    chk("R9 pulse end", {7'b0, rst_out_n}, 8'd1);

    // R10 source uv-only blocks watchdog pulse
    wr(3'd0, 8'h28);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R10 wd blocked", {7'b0, rst_out_n}, 8'd1);
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, 1'b0);

    // R10 either source: undervoltage
    wr(3'd0, 8'h48);
    wr(3'd3, 8'hFF);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R10 uv low", {7'b0, rst_out_n}, 8'd0);
    rd(3'd3, v); chk("R8 uv status", v, 8'h02);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R10 uv release", {7'b0, rst_out_n}, 8'd1);

    // R10 watchdog-only source ignores undervoltage
    wr(3'd0, 8'h08);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R10 uv ignored", {7'b0, rst_out_n}, 8'd1);

    finish_run();
  end
endmodule